// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block holds the tag, valid and dirty state of a direct-mapped, write-back data cache with 32-byte lines and 64 sets. Maintenance commands arrive as a coprocessor-style register write. The write carries a 4-bit CRm selector, a 3-bit opcode_2 selector and a 32-bit data word. For line commands, bits [31:5] of the data word give the line address. The data array, address translation and line refill are handled elsewhere. Evicted and cleaned lines leave through a write-back port, which sends one line address per transfer.

Loads and stores from the pipeline are also looked up here, and a store hit marks its line dirty. The line-allocate command claims a tag without fetching any data. It waits until the memory system reports idle before it acts. If the slot it picks holds a dirty line with a different tag, that line is written back first.

The command port and the access port use valid/ready. A command is taken only while the controller is idle, so `cmd_ready` falls while `busy` is high. An access is taken only when the controller is idle and no command is offered. The write-back port follows valid/ready: once `wb_valid` rises, `wb_addr` stays fixed until `wb_ready` is seen, and `busy` stays high for that whole time.

Top module: `dcache_maint_ctrl`

## Requirements
- R1: After reset every set is invalid and clean, `busy` and `wb_valid` are low, and every lookup misses.
- R2: The supported (CRm, opcode_2) pairs are invalidate-all (0110, 000), invalidate-line (0110, 001), clean-line (1010, 001), drain (1010, 100) and allocate-line (0010, 101). Any other pair pulses `cmd_illegal` in the cycle after acceptance, leaves `busy` low and changes no valid or dirty bit.
- R3: An accepted access returns `acc_resp_valid` one cycle later. `acc_hit` is high when the set indexed by address bits [10:5] is valid, its tag equals bits [31:11] and the cache is enabled. A store hit sets the dirty bit of its line.
- R4: Allocate-line keeps `busy` high and starts no write-back and no tag change while `mem_idle` is low. It acts once `mem_idle` is high.
- R5: Allocate-line aimed at a resident line changes nothing: no write-back, and the dirty bit is kept.
- R6: Allocate-line that displaces a valid dirty line writes back the old line address first. The new line is then installed valid and clean, so displacing it later causes no write-back.
- R7: Clean-line on a dirty resident line writes that line back, clears its dirty bit and keeps it valid. On a clean line or a miss it does nothing.
- R8: Invalidate-line clears the valid bit of a matching line without a write-back and drops its dirty state. A non-matching address leaves the set unchanged. Invalidate-all does this for every set.
- R9: Drain keeps `busy` high until `mem_idle` is seen high, then returns to idle.
- R10: While `wb_valid` is high and `wb_ready` is low, `wb_valid` stays high and `wb_addr` stays stable.
- R11: `parity_fault` pulses in the cycle after accepting a clean-line on a resident line while `data_par_err` is high. No other command raises it.
- R12: With `cache_en` low, accesses miss and do not set dirty bits. Maintenance commands still work. Toggling `cache_en` keeps all valid and dirty bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Cache enable for lookups |
| mem_idle | input | 1 | No memory traffic outstanding |
| data_par_err | input | 1 | Parity error from the data array read |
| cmd_valid | input | 1 | Maintenance command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_crm | input | 4 | Command CRm selector |
| cmd_op2 | input | 3 | Command opcode_2 selector |
| cmd_data | input | 32 | Line address or ignored word |
| acc_valid | input | 1 | Load/store lookup offered |
| acc_ready | output | 1 | Lookup accepted this cycle if valid |
| acc_store | input | 1 | Lookup is a store |
| acc_addr | input | 32 | Lookup address |
| acc_resp_valid | output | 1 | Lookup result valid |
| acc_hit | output | 1 | Lookup hit |
| wb_valid | output | 1 | Write-back line address offered |
| wb_ready | input | 1 | Memory accepts the write-back |
| wb_addr | output | 32 | Line address written back |
| busy | output | 1 | A command is still in progress |
| cmd_illegal | output | 1 | Unsupported command pulse |
| parity_fault | output | 1 | Parity fault from clean-line |

## Verification
The assertions assume that the environment never raises `cmd_valid` and `acc_valid` while a command is in flight. They also assume that `wb_ready` is a plain handshake input with no relation to `wb_addr`, and that `mem_idle` can drop at any time without breaking a transfer already offered. The stimulus drives every input on the falling edge. It offers a command only when `busy` is low, and it answers each write-back after a chosen number of stall cycles.

Lookups are made only between commands, so each `acc_hit` reflects settled state. The illegal-command sweep covers all 128 selector pairs except the five supported ones. During the sweep, the data word points at a dirty line, so any hidden state change would show up in the clean that follows.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [2:0] {
    OP_INV_ALL,
    OP_INV_LINE,
    OP_CLEAN,
    OP_DRAIN,
    OP_ALLOC,
    OP_BAD
  } dcm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_WB
  } dcm_state_e;
endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
  import dcm_pkg::*;
(
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output dcm_op_e    op
);
  always_comb begin
    unique case ({crm, op2})
      7'b0110_000: op = OP_INV_ALL;
      7'b0110_001: op = OP_INV_LINE;
      7'b1010_001: op = OP_CLEAN;
      7'b1010_100: op = OP_DRAIN;
      7'b0010_101: op = OP_ALLOC;
      default:     op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
  parameter int SETS  = 64,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (clr_all) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end
endmodule

// File: rtl/dcm_wb_port.sv
module dcm_wb_port #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              done
);
  assign done = wb_valid && wb_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_addr  <= addr_in;
    end else if (done) begin
      wb_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dcache_maint_ctrl.sv
module dcache_maint_ctrl
  import dcm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 32,
  parameter int SETS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              mem_idle,
  input  logic              data_par_err,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_crm,
  input  logic [2:0]        cmd_op2,
  input  logic [ADDR_W-1:0] cmd_data,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_resp_valid,
  output logic              acc_hit,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              busy,
  output logic              cmd_illegal,
  output logic              parity_fault
);
  localparam int OFF_W = $clog2(LINE_B);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  dcm_state_e       state, nxt_state;
  dcm_op_e          cur_op, dec_op;
  logic [IDX_W-1:0] cur_idx, rd_idx;
  logic [TAG_W-1:0] cur_tag, lk_tag, rd_tag, wr_tag;
  logic             rd_valid, rd_dirty, hit;
  logic             clr_all, wr_en, wr_valid, wr_dirty;
  logic             wb_load, wb_done;
  logic             cmd_fire, acc_fire;
  logic [ADDR_W-1:0] wb_addr_in;
  logic             unused_low;

  assign unused_low = ^{cmd_data[OFF_W-1:0], acc_addr[OFF_W-1:0]};

  dcm_decode u_dec (.crm(cmd_crm), .op2(cmd_op2), .op(dec_op));

  assign cmd_ready = (state == ST_IDLE);
  assign acc_ready = (state == ST_IDLE) && !cmd_valid;
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign acc_fire  = acc_valid && acc_ready;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    if (state != ST_IDLE) begin
      rd_idx = cur_idx;
      lk_tag = cur_tag;
    end else if (cmd_valid) begin
      rd_idx = cmd_data[OFF_W +: IDX_W];
      lk_tag = cmd_data[ADDR_W-1 -: TAG_W];
    end else begin
      rd_idx = acc_addr[OFF_W +: IDX_W];
      lk_tag = acc_addr[ADDR_W-1 -: TAG_W];
    end
  end

  dcm_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .clr_all(clr_all), .wr_en(wr_en), .wr_idx(rd_idx),
    .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_tag(wr_tag)
  );

  assign hit        = rd_valid && (rd_tag == lk_tag);
  assign wb_addr_in = {rd_tag, rd_idx, {OFF_W{1'b0}}};

  dcm_wb_port #(.ADDR_W(ADDR_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .load(wb_load), .addr_in(wb_addr_in),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .done(wb_done)
  );

  always_comb begin
    nxt_state = state;
    clr_all   = 1'b0;
    wr_en     = 1'b0;
    wr_valid  = rd_valid;
    wr_dirty  = rd_dirty;
    wr_tag    = rd_tag;
    wb_load   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmd_fire) begin
          unique case (dec_op)
            OP_INV_ALL: clr_all = 1'b1;
            OP_INV_LINE: if (hit) begin
              wr_en    = 1'b1;
              wr_valid = 1'b0;
              wr_dirty = 1'b0;
            end
            OP_CLEAN: if (hit && rd_dirty) begin
              wb_load   = 1'b1;
              nxt_state = ST_WB;
            end
            OP_DRAIN, OP_ALLOC: nxt_state = ST_WAIT;
            default: ;
          endcase
        end else if (acc_fire && acc_store && cache_en && hit) begin
          wr_en    = 1'b1;
          wr_dirty = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_idle) begin
          if (cur_op == OP_DRAIN || hit) begin
            nxt_state = ST_IDLE;
          end else if (rd_valid && rd_dirty) begin
            wb_load   = 1'b1;
            nxt_state = ST_WB;
          end else begin
            wr_en     = 1'b1;
            wr_valid  = 1'b1;
            wr_dirty  = 1'b0;
            wr_tag    = cur_tag;
            nxt_state = ST_IDLE;
          end
        end
      end
      ST_WB: begin
        if (wb_done) begin
          wr_en     = 1'b1;
          wr_dirty  = 1'b0;
          nxt_state = ST_IDLE;
          if (cur_op == OP_ALLOC) begin
            wr_valid = 1'b1;
            wr_tag   = cur_tag;
          end
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      cur_op         <= OP_BAD;
      cur_idx        <= '0;
      cur_tag        <= '0;
      cmd_illegal    <= 1'b0;
      parity_fault   <= 1'b0;
      acc_resp_valid <= 1'b0;
      acc_hit        <= 1'b0;
    end else begin
      state          <= nxt_state;
      cmd_illegal    <= cmd_fire && (dec_op == OP_BAD);
      parity_fault   <= cmd_fire && (dec_op == OP_CLEAN) && hit && data_par_err;
      acc_resp_valid <= acc_fire;
      acc_hit        <= acc_fire && cache_en && hit;
      if (cmd_fire) begin
        cur_op  <= dec_op;
        cur_idx <= rd_idx;
        cur_tag <= lk_tag;
      end
    end
  end
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cache_en,
  input logic              mem_idle,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_crm,
  input logic [2:0]        cmd_op2,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_resp_valid,
  input logic              acc_hit,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              busy,
  input logic              cmd_illegal,
  input logic              parity_fault
);
  // R2
  illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_illegal |-> (!busy && !wb_valid));

  // R3
  resp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_resp_valid |-> $past(acc_valid && acc_ready));

  // R4
  alloc_waits_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_idle && !wb_valid) |=> !wb_valid);

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

  // R10
  wb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);

  // R11
  parity_clean_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_fault |-> $past(cmd_valid && cmd_ready && cmd_crm == 4'b1010 && cmd_op2 == 3'b001));

  // R12
  hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_resp_valid && acc_hit) |-> $past(cache_en));
endmodule

bind dcache_maint_ctrl dcm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .mem_idle(mem_idle),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_crm(cmd_crm),
  .cmd_op2(cmd_op2), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_resp_valid(acc_resp_valid), .acc_hit(acc_hit),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
  .busy(busy), .cmd_illegal(cmd_illegal), .parity_fault(parity_fault)
);

// File: tb/sim_dcache_maint_ctrl.sv
`timescale 1ns/1ps
module sim_dcache_maint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b1, mem_idle = 1'b1, data_par_err = 1'b0;
  logic        cmd_valid = 1'b0, acc_valid = 1'b0, acc_store = 1'b0, wb_ready = 1'b0;
  logic [3:0]  cmd_crm = '0;
  logic [2:0]  cmd_op2 = '0;
  logic [31:0] cmd_data = '0, acc_addr = '0;
  logic        cmd_ready, acc_ready, acc_resp_valid, acc_hit, wb_valid, busy;
  logic        cmd_illegal, parity_fault;
  logic [31:0] wb_addr;

  int tests = 0, fails = 0;
  int wb_cnt = 0, wb_hold = 0;
  logic [31:0] wb_last = '0;
  logic ill_s, par_s, hit_s;

  always #5 clk = ~clk;

  dcache_maint_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .mem_idle(mem_idle),
    .data_par_err(data_par_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_crm(cmd_crm), .cmd_op2(cmd_op2), .cmd_data(cmd_data),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_store(acc_store),
    .acc_addr(acc_addr), .acc_resp_valid(acc_resp_valid), .acc_hit(acc_hit),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .busy(busy),
    .cmd_illegal(cmd_illegal), .parity_fault(parity_fault)
  );

  function automatic logic [31:0] la(input int t, input int i);
    return {t[20:0], i[5:0], 5'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_crm = crm; cmd_op2 = op2; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    ill_s = cmd_illegal;
    par_s = parity_fault;
  endtask

  task automatic service();
    for (int n = 0; n < 200; n++) begin
      if (wb_ready) wb_ready = 1'b0;
      if (wb_valid) begin
        wb_last = wb_addr;
        if (wb_hold > 0) wb_hold--;
        else begin wb_ready = 1'b1; wb_cnt++; end
      end else if (!busy) return;
      @(negedge clk);
    end
    chk("R10 service timeout", 32'(busy), 32'd0);
  endtask

  task automatic cmd(input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] d);
    issue(crm, op2, d);
    service();
  endtask

  task automatic look(input logic st, input logic [31:0] a);
    acc_valid = 1'b1; acc_store = st; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0; acc_store = 1'b0;
    hit_s = acc_hit;
    chk("R3 resp valid", 32'(acc_resp_valid), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    for (int i = 0; i < 64; i++) begin look(1'b0, la(i + 1, i)); chk("R1 miss", 32'(hit_s), 0); end

    // R6 allocate fills every set with no write-back
    for (int i = 0; i < 64; i++) cmd(4'b0010, 3'b101, la(i + 1, i));
    chk("R6 no wb on empty", wb_cnt, 0);
    for (int i = 0; i < 64; i++) begin
      look(1'b0, la(i + 1, i)); chk("R3 hit", 32'(hit_s), 1);
      look(1'b0, la(i + 2, i)); chk("R3 tag miss", 32'(hit_s), 0);
    end

    // R5 resident allocate keeps dirty
    look(1'b1, la(4, 3));
    cmd(4'b0010, 3'b101, la(4, 3));
    chk("R5 no wb", wb_cnt, 0);
    look(1'b0, la(4, 3)); chk("R5 still hit", 32'(hit_s), 1);
    // R7 clean
    cmd(4'b1010, 3'b001, la(4, 3));
    chk("R7 clean wb", wb_cnt, 1);
    chk("R7 clean addr", wb_last, la(4, 3));
    cmd(4'b1010, 3'b001, la(4, 3));
    chk("R7 second clean no wb", wb_cnt, 1);
    look(1'b0, la(4, 3)); chk("R7 valid kept", 32'(hit_s), 1);
    cmd(4'b1010, 3'b001, la(77, 3));
    chk("R7 miss clean no wb", wb_cnt, 1);

    // R6 dirty victim with stalled write-back (R10)
    look(1'b1, la(8, 7));
    wb_hold = 4;
    cmd(4'b0010, 3'b101, la(30, 7));
    chk("R6 victim wb", wb_cnt, 2);
    chk("R10 victim addr", wb_last, la(8, 7));
    look(1'b0, la(30, 7)); chk("R6 new hit", 32'(hit_s), 1);
    look(1'b0, la(8, 7)); chk("R6 old miss", 32'(hit_s), 0);
    cmd(4'b0010, 3'b101, la(31, 7));
    chk("R6 new line clean", wb_cnt, 2);

    // R4 allocate waits for mem_idle
    look(1'b1, la(10, 9));
    mem_idle = 1'b0;
    issue(4'b0010, 3'b101, la(41, 9));
    for (int k = 0; k < 5; k++) begin
      chk("R4 busy", 32'(busy), 1);
      chk("R4 no wb", 32'(wb_valid), 0);
      @(negedge clk);
    end
    mem_idle = 1'b1;
    service();
    chk("R4 wb after idle", wb_cnt, 3);
    chk("R4 wb addr", wb_last, la(10, 9));
    look(1'b0, la(41, 9)); chk("R4 installed", 32'(hit_s), 1);

    // R9 drain
    mem_idle = 1'b0;
    issue(4'b1010, 3'b100, 32'hDEAD_BEEF);
    for (int k = 0; k < 3; k++) begin chk("R9 busy", 32'(busy), 1); @(negedge clk); end
    mem_idle = 1'b1;
    service();
    chk("R9 idle", 32'(busy), 0);
    chk("R2 drain legal", 32'(ill_s), 0);

    // R11 parity
    data_par_err = 1'b1;
    cmd(4'b1010, 3'b001, la(41, 9)); chk("R11 clean resident", 32'(par_s), 1);
    cmd(4'b1010, 3'b001, la(50, 9)); chk("R11 clean miss", 32'(par_s), 0);
    cmd(4'b0110, 3'b001, la(50, 9)); chk("R11 inv line", 32'(par_s), 0);
    cmd(4'b0010, 3'b101, la(41, 9)); chk("R11 alloc", 32'(par_s), 0);
    data_par_err = 1'b0;
    cmd(4'b1010, 3'b001, la(41, 9)); chk("R11 no err", 32'(par_s), 0);

    // R8 invalidate line
    look(1'b1, la(41, 9));
    w0 = wb_cnt;
    cmd(4'b0110, 3'b001, la(41, 9));
    chk("R8 inv no wb", wb_cnt, w0);
    look(1'b0, la(41, 9)); chk("R8 inv miss", 32'(hit_s), 0);
    cmd(4'b0010, 3'b101, la(42, 9));
    chk("R8 dirty dropped", wb_cnt, w0);
    cmd(4'b0110, 3'b001, la(99, 4));
    look(1'b0, la(5, 4)); chk("R8 other tag kept", 32'(hit_s), 1);

    // R2 illegal sweep against a dirty line
    look(1'b1, la(5, 4));
    for (int c = 0; c < 16; c++)
      for (int o = 0; o < 8; o++) begin
        logic [6:0] p;
        p = {c[3:0], o[2:0]};
        if (p == 7'b0110_000 || p == 7'b0110_001 || p == 7'b1010_001 ||
            p == 7'b1010_100 || p == 7'b0010_101) continue;
        issue(c[3:0], o[2:0], la(5, 4));
        chk("R2 illegal pulse", 32'(ill_s), 1);
        chk("R2 not busy", 32'(busy), 0);
      end
    @(negedge clk);
    chk("R2 pulse ends", 32'(cmd_illegal), 0);
    look(1'b0, la(5, 4)); chk("R2 line kept", 32'(hit_s), 1);
    w0 = wb_cnt;
    cmd(4'b1010, 3'b001, la(5, 4));
    chk("R2 dirty kept", wb_cnt, w0 + 1);
    chk("R2 clean legal", 32'(ill_s), 0);

    // R12 enable control
    cache_en = 1'b0;
    look(1'b0, la(5, 4)); chk("R12 disabled miss", 32'(hit_s), 0);
    look(1'b1, la(12, 11));
    cmd(4'b0010, 3'b101, la(60, 20));
    cache_en = 1'b1;
    w0 = wb_cnt;
    cmd(4'b1010, 3'b001, la(12, 11));
    chk("R12 no dirty when off", wb_cnt, w0);
    look(1'b0, la(12, 11)); chk("R12 kept", 32'(hit_s), 1);
    look(1'b0, la(60, 20)); chk("R12 alloc while off", 32'(hit_s), 1);
    look(1'b1, la(60, 20));
    cache_en = 1'b0; @(negedge clk); cache_en = 1'b1;
    cmd(4'b1010, 3'b001, la(60, 20));
    chk("R12 dirty kept over toggle", wb_cnt, w0 + 1);

    // R8 invalidate all
    look(1'b1, la(13, 12));
    w0 = wb_cnt;
    cmd(4'b0110, 3'b000, 32'h0);
    for (int i = 0; i < 64; i++) begin look(1'b0, la(i + 1, i)); chk("R8 all miss", 32'(hit_s), 0); end
    cmd(4'b0010, 3'b101, la(70, 12));
    chk("R8 all no wb", wb_cnt, w0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule